// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block sits between a host microprocessor bus and a small internal register space. It takes either of two common strobe styles and turns them into one read strobe and one write strobe. The style is picked by a static mode pin. The first style has separate active-low read and write lines qualified by chip select. The second has one active-low data strobe and a read/write direction line, also qualified by chip select. Direct registers are written and read at their own addresses. A banked parameter RAM is reached indirectly. The host loads a shared access data register, then writes a bank index into an odd select address to store that value. Writing an even select address fetches a RAM word into the access data register.

Writes are handed to a slow internal clock. That clock is a tick enable made by dividing the bus-side clock. An active-low READY handshake tells the host when each access has completed. Indirect operations open a hold-off window counted in slow ticks. During that window a write to a protected address is stalled, not dropped. One bit of the mode register lets writes bypass the slow-clock wait.

Top module: `hostbus_regif`

## Requirements
- R1: With `busMode`=0, a read is active while `csN` and `rdN` are both low, and a write is active while `csN` and `wrN` are both low.
- R2: With `busMode`=1, an access is active while `csN` and `dsN` are both low. It is a read when `rwN`=1 and a write when `rwN`=0.
- R3: In synchronous mode, an accepted write takes effect at the first slow tick after acceptance. Slow ticks fall on every DIV-th rising clock edge after reset is released. Until that tick, a read of the same address returns the old value.
- R4: Bit 0 of the mode register at address 0x0F selects the mode: 1 is asynchronous, 0 is synchronous. In asynchronous mode a write takes effect one clock after acceptance and is readable at once.
- R5: Address 0x7C is the access data register. A write of value v to odd address 0x71+2k stores the access data register into RAM bank k at entry v[2:0], for k from 0 to 5.
- R6: A write of value v to even address 0x70+2k fetches RAM bank k entry v[2:0] into the access data register. The fetched value arrives HOLD_RD slow ticks after that write takes effect.
- R7: Writes to a protected address are stalled with READY held high until the hold-off window ends, and are then performed. After an indirect store, the protected addresses are the select addresses and 0x7C, for HOLD_WR ticks. After a fetch, they are the select addresses until the data lands.
- R8: `ready` goes low on the 2nd rising edge after a read strobe starts, with `rdata` valid from then on. For an unstalled write it goes low on the 3rd edge. It returns high on the 2nd edge after the strobe ends.
- R9: `dataOe` is high exactly while a read strobe is active at the pins, and low otherwise.
- R10: After reset `ready`=1, `dataOe`=0, all registers and the access data register read 0, and the mode is synchronous.
- R11: Addresses 0x10–0x6F, 0x70–0x7B and 0x7D–0x7F read as 0. Writes to 0x10–0x6F and 0x7D–0x7F have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-side clock; the slow clock is divided from it |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 1 | Strobe style: 0 separate read/write lines, 1 data strobe with direction |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read line, active low (busMode=0) |
| wrN | input | 1 | Write line, active low (busMode=0) |
| dsN | input | 1 | Data strobe, active low (busMode=1) |
| rwN | input | 1 | Direction, 1 read / 0 write (busMode=1) |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| dataOe | output | 1 | Data bus output enable |
| ready | output | 1 | Access complete, active low |

## Verification
Read results are sampled after the 2nd rising edge from the start of the strobe. Write acknowledge is counted in falling edges from the start of the strobe, and an unstalled write must give exactly 3. Stalled writes are checked against a window measured in multiples of DIV. For the synchronous-versus-asynchronous check, the bench aligns a write to a known slow-tick phase. A read issued right after acceptance then falls before the commit tick in synchronous mode and after the commit in asynchronous mode. Indirect fetches and stores are only read back after more than HOLD_WR+1 or HOLD_RD+1 slow periods.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam logic [AW-1:0] SEL_BASE  = 7'h70;
  localparam logic [AW-1:0] SEL_LAST  = 7'h7B;
  localparam logic [AW-1:0] ADR_ADDR  = 7'h7C;
  localparam logic [AW-1:0] MODE_ADDR = 7'h0F;
  localparam int NBANK = (int'(SEL_LAST) - int'(SEL_BASE) + 1) / 2;

  typedef struct packed {
    logic          commit;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          rdLoad;
    logic          rdCap;
    logic [AW-1:0] rdAddr;
  } ctlStb_t;

  function automatic logic isSelAddr(input logic [AW-1:0] a);
    return (a >= SEL_BASE) && (a <= SEL_LAST);
  endfunction
endpackage

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hostbus_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int HOLD_WR = 3,
  parameter int HOLD_RD = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busMode,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic          dsN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          asyncMode,
  output logic          rdActive,
  output logic          ready,
  output ctlStb_t       ctl
);
  localparam int HMAX = (HOLD_WR > HOLD_RD) ? HOLD_WR : HOLD_RD;
  localparam int HCW  = $clog2(HMAX + 1);
  localparam int DCW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic rdRaw, wrRaw, rdQ, wrQ, wrTaken, pendValid, holdAdr, readyQ;
  logic [AW-1:0] addrQ, pendAddr;
  logic [DW-1:0] dataQ, pendData;
  logic [DCW-1:0] divCnt;
  logic [HCW-1:0] holdCnt;
  logic tick, blocked, accept, commit, selCommit, rdLoad;

  always_comb begin
    if (busMode) begin
      rdRaw = !csN && !dsN && rwN;
      wrRaw = !csN && !dsN && !rwN;
    end else begin
      rdRaw = !csN && !rdN;
      wrRaw = !csN && !wrN;
    end
  end

  assign tick      = (divCnt == DCW'(DIV - 1));
  assign blocked   = pendValid || ((holdCnt != '0) &&
                     (isSelAddr(addrQ) || ((addrQ == ADR_ADDR) && holdAdr)));
  assign accept    = wrQ && !wrTaken && !blocked;
  assign commit    = pendValid && (tick || asyncMode);
  assign selCommit = commit && isSelAddr(pendAddr);
  assign rdLoad    = tick && (holdCnt == HCW'(1)) && !holdAdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= 1'b0; wrQ <= 1'b0; addrQ <= '0; dataQ <= '0;
      divCnt <= '0; wrTaken <= 1'b0; pendValid <= 1'b0;
      pendAddr <= '0; pendData <= '0; holdCnt <= '0; holdAdr <= 1'b0;
      readyQ <= 1'b1;
    end else begin
      rdQ   <= rdRaw;
      wrQ   <= wrRaw;
      addrQ <= addr;
      dataQ <= wdata;
      divCnt <= tick ? '0 : divCnt + DCW'(1);
      if (!wrQ) wrTaken <= 1'b0;
      else if (accept) wrTaken <= 1'b1;
      if (accept) begin
        pendValid <= 1'b1;
        pendAddr  <= addrQ;
        pendData  <= dataQ;
      end else if (commit) begin
        pendValid <= 1'b0;
      end
      if (selCommit) begin
        holdCnt <= pendAddr[0] ? HCW'(HOLD_WR) : HCW'(HOLD_RD);
        holdAdr <= pendAddr[0];
      end else if (tick && holdCnt != '0) begin
        holdCnt <= holdCnt - HCW'(1);
      end
      readyQ <= !(rdQ || (wrQ && wrTaken));
    end
  end

  assign rdActive   = rdRaw;
  assign ready      = readyQ;
  assign ctl.commit = commit;
  assign ctl.addr   = pendAddr;
  assign ctl.data   = pendData;
  assign ctl.rdLoad = rdLoad;
  assign ctl.rdCap  = rdQ;
  assign ctl.rdAddr = addrQ;

  // R3: synchronous commits only on a slow tick
  p_commit_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !asyncMode) |-> tick);
  // R4: asynchronous mode drains the pending write in one clock
  p_async_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && asyncMode) |=> !pendValid);
  // R7: a select write only takes effect outside a hold-off window
  p_sel_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    selCommit |-> (holdCnt == '0));
  // R8: ready low only follows a registered strobe
  p_ready_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> $past(rdQ || wrQ));
  // R8: ready released one clock after the registered strobe ends
  p_ready_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdQ || wrQ) |=> ready);
endmodule

// File: rtl/hostbus_store.sv
module hostbus_store
  import hostbus_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int BANKD = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStb_t       ctl,
  output logic [DW-1:0] rdata,
  output logic          asyncMode
);
  localparam int RW   = $clog2(NREG);
  localparam int IDXW = $clog2(BANKD);
  localparam int RAMN = NBANK * BANKD;
  localparam int RIW  = $clog2(RAMN);

  logic [DW-1:0] regFile [NREG];
  logic [DW-1:0] ram [RAMN];
  logic [DW-1:0] adrQ, rdataQ, rdMux;
  logic [RIW-1:0] rdIdxQ, wrIdx;
  logic isDirect, isSel;

  assign isDirect = int'(ctl.addr) < NREG;
  assign isSel    = isSelAddr(ctl.addr);
  assign wrIdx    = RIW'(((int'(ctl.addr) - int'(SEL_BASE)) / 2) * BANKD
                         + int'(ctl.data[IDXW-1:0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
      for (int i = 0; i < RAMN; i++) ram[i] <= '0;
      adrQ   <= '0;
      rdIdxQ <= '0;
    end else begin
      if (ctl.rdLoad) adrQ <= ram[rdIdxQ];
      if (ctl.commit) begin
        if (isDirect) regFile[ctl.addr[RW-1:0]] <= ctl.data;
        if (ctl.addr == ADR_ADDR) adrQ <= ctl.data;
        if (isSel && ctl.addr[0]) ram[wrIdx] <= adrQ;
        if (isSel && !ctl.addr[0]) rdIdxQ <= wrIdx;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (int'(ctl.rdAddr) < NREG) rdMux = regFile[ctl.rdAddr[RW-1:0]];
    else if (ctl.rdAddr == ADR_ADDR) rdMux = adrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (ctl.rdCap) rdataQ <= rdMux;
  end

  assign rdata     = rdataQ;
  assign asyncMode = regFile[MODE_ADDR[RW-1:0]][0];

  // R6: a fetch never coincides with a store into the RAM
  p_fetch_no_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdLoad |-> !(ctl.commit && isSel && ctl.addr[0]));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
  import hostbus_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int HOLD_WR = 3,
  parameter int HOLD_RD = 2,
  parameter int NREG    = 16,
  parameter int BANKD   = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busMode,
  input  logic          csN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic          dsN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          dataOe,
  output logic          ready
);
  ctlStb_t ctl;
  logic asyncMode;

  hostbus_ctrl #(.DIV(DIV), .HOLD_WR(HOLD_WR), .HOLD_RD(HOLD_RD)) uCtrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN), .rdN(rdN),
    .wrN(wrN), .dsN(dsN), .rwN(rwN), .addr(addr), .wdata(wdata),
    .asyncMode(asyncMode), .rdActive(dataOe), .ready(ready), .ctl(ctl)
  );

  hostbus_store #(.NREG(NREG), .BANKD(BANKD)) uStore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdata(rdata), .asyncMode(asyncMode)
  );
endmodule

// File: tb/tb_hostbus_regif.sv
module tb_hostbus_regif;
  localparam int PERIOD = 10;
  localparam int DIV = 8, HOLD_WR = 3, HOLD_RD = 2;

  logic clk = 0, rstN = 0, busMode = 0;
  logic csN = 1, rdN = 1, wrN = 1, dsN = 1, rwN = 1;
  logic [6:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic dataOe, ready;
  int checks = 0, fails = 0, edgeN = 0;
  logic [7:0] mReg [16];
  logic [7:0] mRam [48];
  logic [7:0] mAdr;

  hostbus_regif #(.DIV(DIV), .HOLD_WR(HOLD_WR), .HOLD_RD(HOLD_RD)) dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN), .rdN(rdN),
    .wrN(wrN), .dsN(dsN), .rwN(rwN), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dataOe(dataOe), .ready(ready));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) edgeN <= edgeN + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic m);
    return m ? "R2" : "R1";
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    csN = 1; rdN = 1; wrN = 1; dsN = 1; rwN = 1;
  endtask

  task automatic busWrite(input logic m, input logic [6:0] a, input logic [7:0] d,
                          output int lat);
    busMode = m; addr = a; wdata = d; csN = 0;
    if (m) begin dsN = 0; rwN = 0; end else wrN = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (ready && lat < 1000);
    release_bus();
    idle(2);
    chk(ready == 1'b1, "R8 ready release after write", int'(ready), 1);
  endtask

  task automatic busRead(input logic m, input logic [6:0] a, output logic [7:0] d);
    busMode = m; addr = a; csN = 0;
    if (m) begin dsN = 0; rwN = 1; end else rdN = 0;
    #1 chk(dataOe == 1'b1, "R9 oe during read", int'(dataOe), 1);
    @(negedge clk);
    chk(ready == 1'b1, "R8 ready high after 1 edge", int'(ready), 1);
    @(negedge clk);
    chk(ready == 1'b0, {"R8 ready low after 2 edges ", modeTag(m)}, int'(ready), 0);
    d = rdata;
    release_bus();
    #1 chk(dataOe == 1'b0, "R9 oe after read", int'(dataOe), 0);
    idle(2);
    chk(ready == 1'b1, "R8 ready release after read", int'(ready), 1);
  endtask

  task automatic writeThenRead(input logic [6:0] a, input logic [7:0] d,
                               output logic [7:0] q);
    while (edgeN % DIV != 0) @(negedge clk);
    busMode = 0; addr = a; wdata = d; csN = 0; wrN = 0;
    repeat (3) @(negedge clk);
    wrN = 1; rdN = 0;
    repeat (2) @(negedge clk);
    q = rdata;
    release_bus();
    idle(2);
  endtask

  task automatic wrDirect(input logic m, input logic [6:0] a, input logic [7:0] d);
    int lat;
    busWrite(m, a, d, lat);
    chk(lat == 3, {"R8 write ack latency ", modeTag(m)}, lat, 3);
    if (int'(a) < 16) mReg[a[3:0]] = d;
    if (a == 7'h7C) mAdr = d;
    idle(2 * DIV);
  endtask

  task automatic selStore(input logic m, input int k, input logic [2:0] idx);
    int lat;
    busWrite(m, 7'(8'h71 + 2 * k), {5'd0, idx}, lat);
    mRam[k * 8 + int'(idx)] = mAdr;
    idle((HOLD_WR + 2) * DIV);
  endtask

  task automatic selFetch(input logic m, input int k, input logic [2:0] idx);
    int lat;
    busWrite(m, 7'(8'h70 + 2 * k), {5'd0, idx}, lat);
    mAdr = mRam[k * 8 + int'(idx)];
    idle((HOLD_RD + 2) * DIV);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int lat, seed;
    seed = $urandom(20240611);
    for (int i = 0; i < 16; i++) mReg[i] = 0;
    for (int i = 0; i < 48; i++) mRam[i] = 0;
    mAdr = 0;
    idle(3);
    chk(ready == 1'b1, "R10 reset ready", int'(ready), 1);
    chk(dataOe == 1'b0, "R10 reset oe", int'(dataOe), 0);
    rstN = 1;
    idle(2);
    busRead(0, 7'h05, q);  chk(q == 8'h00, "R10 reset reg", int'(q), 0);
    busRead(1, 7'h7C, q);  chk(q == 8'h00, "R10 reset access data", int'(q), 0);
    busRead(0, 7'h0F, q);  chk(q == 8'h00, "R10 reset mode sync", int'(q), 0);

    // R1 R2 random direct traffic in both styles
    for (int i = 0; i < 40; i++) begin
      logic m; logic [6:0] a; logic [7:0] d;
      m = 1'($urandom); a = 7'($urandom % 15); d = 8'($urandom);
      wrDirect(m, a, d);
      m = 1'($urandom);
      busRead(m, a, q);
      chk(q == mReg[a[3:0]], {modeTag(m), " direct readback"}, int'(q), int'(mReg[a[3:0]]));
    end

    // R11 unmapped and select addresses
    wrDirect(0, 7'h20, 8'h55);
    busRead(0, 7'h20, q); chk(q == 8'h00, "R11 unmapped read", int'(q), 0);
    wrDirect(1, 7'h7E, 8'h66);
    busRead(1, 7'h7E, q); chk(q == 8'h00, "R11 unmapped high read", int'(q), 0);
    busRead(0, 7'h71, q); chk(q == 8'h00, "R11 select reads zero", int'(q), 0);
    for (int i = 0; i < 15; i++) begin
      busRead(0, 7'(i), q);
      chk(q == mReg[i], "R11 no side effect on registers", int'(q), int'(mReg[i]));
    end

    // R3 synchronous: read right after acceptance sees old value
    writeThenRead(7'h03, 8'h5A, q);
    chk(q == mReg[3], "R3 old value before tick", int'(q), int'(mReg[3]));
    mReg[3] = 8'h5A;
    idle(2 * DIV);
    busRead(0, 7'h03, q); chk(q == 8'h5A, "R3 value after tick", int'(q), 'h5A);

    // R4 asynchronous mode
    wrDirect(0, 7'h0F, 8'h01);
    writeThenRead(7'h03, 8'hC3, q);
    chk(q == 8'hC3, "R4 async immediate", int'(q), 'hC3);
    mReg[3] = 8'hC3;
    wrDirect(0, 7'h0F, 8'h00);
    busRead(0, 7'h0F, q); chk(q == 8'h00, "R4 mode cleared", int'(q), 0);

    // R5 R6 random indirect traffic
    for (int i = 0; i < 20; i++) begin
      int k; logic [2:0] idx;
      k = int'($urandom % 6); idx = 3'($urandom);
      wrDirect(1'($urandom), 7'h7C, 8'($urandom));
      selStore(1'($urandom), k, idx);
    end
    for (int i = 0; i < 20; i++) begin
      int k; logic [2:0] idx;
      k = int'($urandom % 6); idx = 3'($urandom);
      selFetch(1'($urandom), k, idx);
      busRead(0, 7'h7C, q);
      chk(q == mAdr, "R6 fetch into access data", int'(q), int'(mAdr));
    end
    wrDirect(0, 7'h7C, 8'h9E);
    selStore(0, 5, 3'd7);
    selFetch(1, 5, 3'd7);
    busRead(0, 7'h7C, q); chk(q == 8'h9E, "R5 top bank top entry", int'(q), 'h9E);

    // R7 stall after indirect store
    wrDirect(0, 7'h7C, 8'h11);
    busWrite(0, 7'h75, 8'h05, lat);
    mRam[2 * 8 + 5] = 8'h11;
    busWrite(1, 7'h7C, 8'h22, lat);
    chk(lat >= 2 * DIV && lat <= (HOLD_WR + 2) * DIV + 4, "R7 access data write stalled",
        lat, 2 * DIV);
    mAdr = 8'h22;
    idle(2 * DIV);
    busRead(0, 7'h7C, q); chk(q == 8'h22, "R7 stalled write performed", int'(q), 'h22);

    // R7 stall after fetch
    busWrite(0, 7'h74, 8'h05, lat);
    mAdr = 8'h11;
    busWrite(0, 7'h77, 8'h01, lat);
    chk(lat >= DIV && lat <= (HOLD_RD + 2) * DIV + 4, "R7 select write stalled", lat, DIV);
    mRam[3 * 8 + 1] = mAdr;
    idle((HOLD_WR + 2) * DIV);
    busRead(0, 7'h7C, q); chk(q == 8'h11, "R6 fetched before stalled store", int'(q), 'h11);
    selFetch(0, 3, 3'd1);
    busRead(1, 7'h7C, q); chk(q == 8'h11, "R7 stalled store used fetched data", int'(q), 'h11);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule